// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sequences the external memory accesses of a bus master. The core asks for one access at a time through a request pulse, a write flag, a 24-bit address and a 32-bit write value. The controller then asserts the chip select of the addressed bank and the active-low read or write strobe. It keeps the strobe asserted for a length set by that bank's wait settings. It finishes with a one-cycle done pulse, and for a read it returns the data captured from the bus.

The two top address bits pick one of four banks. Each bank has a 3-bit wait count, a 2-bit wait mode, a hold enable and an idle enable. The wait mode sets how the programmed count and the external acknowledge input end the strobe phase. The count can act alone, the acknowledge can act alone, either one can end the strobe, or both must have been met. When hold is enabled, the chip select and address stay valid for one cycle after the strobe is removed. When idle is enabled, a dead cycle follows with every select released, before the next access may start.

Top module: `ebus_wait_ctrl`

## Requirements
- R1: After reset all chip selects and both strobes are high (inactive), `done_o` is low and `ready_o` is high.
- R2: During an access exactly one select is low, the one whose index equals address bits [23:22], and the bus address holds the value captured at acceptance even if `addr_i` changes.
- R3: A read (`we_i`=0) drives only `bus_rd_n_o` low and a write drives only `bus_wr_n_o` low, never both; during a write `bus_wdata_o` equals the captured write value.
- R4: Mode 0 (count only): the strobe lasts W+1 cycles, where W is the bank's wait count, and `ack_i` has no effect on the length.
- R5: Mode 1 (acknowledge only): `ack_i` is sampled at the end of every strobe cycle from the first one on, and the strobe ends after the first cycle in which it is sampled high.
- R6: Mode 2 (either): the strobe ends after the first cycle in which the count has been reached or `ack_i` is high, giving min(W,A)+1 cycles when `ack_i` is high from strobe cycle A on.
- R7: Mode 3 (both): `ack_i` counts only once the W wait cycles have passed, giving max(W,A)+1 cycles when `ack_i` is high from strobe cycle A on.
- R8: With the bank's hold bit set, one cycle follows the strobe in which both strobes are high while the same select and the same address stay asserted.
- R9: With the bank's idle bit set, one cycle follows the strobe (and any hold cycle) with all selects high and `ready_o` low.
- R10: `done_o` is high for exactly one cycle, the cycle right after the last strobe cycle, and for a read `rdata_o` then holds the bus data present in that last strobe cycle.
- R11: `req_i` is taken only while `ready_o` is high; a request given during a hold or idle cycle starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle access request, taken while ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Access address; bits [23:22] pick the bank |
| wdata_i | input | 32 | Write value |
| rdata_o | output | 32 | Read value, valid with done_o |
| done_o | output | 1 | One-cycle completion pulse |
| ready_o | output | 1 | Controller can accept a request |
| wait_cfg_i | input | 12 | Per-bank 3-bit wait counts, bank b at [3b+2:3b] |
| mode_cfg_i | input | 8 | Per-bank 2-bit wait modes, bank b at [2b+1:2b] |
| hold_cfg_i | input | 4 | Per-bank hold-cycle enables |
| idle_cfg_i | input | 4 | Per-bank idle-cycle enables |
| ack_i | input | 1 | External acknowledge, synchronous |
| bus_addr_o | output | 24 | External address |
| bus_sel_n_o | output | 4 | Active-low bank chip selects |
| bus_rd_n_o | output | 1 | Active-low read strobe |
| bus_wr_n_o | output | 1 | Active-low write strobe |
| bus_wdata_o | output | 32 | External write data |
| bus_rdata_i | input | 32 | External read data |

## Verification
The strobe and select appear in the cycle after the edge that accepts a request. `ack_i` counts at the closing edge of each strobe cycle. `done_o` and `rdata_o` are due one cycle after the last strobe cycle, and the hold cycle, the idle cycle and the return of `ready_o` follow one cycle apart. The bench samples and drives on falling edges and counts the strobe cycles it sees. For each cycle it sets `ack_i` from the index of that cycle, so an acknowledge starting at strobe cycle A lines up with the edge that samples it. Each later event is then checked in the exact cycle that follows from the expected length.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    typedef enum logic [1:0] {
        WM_COUNT  = 2'd0,
        WM_ACK    = 2'd1,
        WM_EITHER = 2'd2,
        WM_BOTH   = 2'd3
    } wait_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_HOLD   = 2'd2,
        ST_TURN   = 2'd3
    } bus_state_e;

endpackage

// File: rtl/ebus_cfg_mux.sv
module ebus_cfg_mux #(
    parameter int ADDR_W = 24,
    parameter int NBANK  = 4,
    parameter int WAIT_W = 3,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [NBANK*WAIT_W-1:0] wait_cfg_i,
    input  logic [NBANK*2-1:0]      mode_cfg_i,
    input  logic [NBANK-1:0]        hold_cfg_i,
    input  logic [NBANK-1:0]        idle_cfg_i,
    output logic [BANK_W-1:0]       bank_o,
    output logic [WAIT_W-1:0]       wait_o,
    output ebus_pkg::wait_mode_e    mode_o,
    output logic                    hold_o,
    output logic                    idle_o
);
    logic [WAIT_W-1:0] wait_arr [NBANK];
    logic [1:0]        mode_arr [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign wait_arr[b] = wait_cfg_i[b*WAIT_W +: WAIT_W];
        assign mode_arr[b] = mode_cfg_i[b*2 +: 2];
    end

    assign bank_o = addr_i[ADDR_W-1 -: BANK_W];
    assign wait_o = wait_arr[bank_o];
    assign mode_o = ebus_pkg::wait_mode_e'(mode_arr[bank_o]);
    assign hold_o = hold_cfg_i[bank_o];
    assign idle_o = idle_cfg_i[bank_o];
endmodule

// File: rtl/ebus_sel_dec.sv
module ebus_sel_dec #(
    parameter int NBANK = 4,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic              en_i,
    output logic [NBANK-1:0]  sel_n_o
);
    for (genvar b = 0; b < NBANK; b++) begin : g_sel
        assign sel_n_o[b] = !(en_i && (bank_i == BANK_W'(b)));
    end
endmodule

// File: rtl/ebus_wait_eval.sv
module ebus_wait_eval #(
    parameter int WAIT_W = 3
) (
    input  ebus_pkg::wait_mode_e mode_i,
    input  logic [WAIT_W-1:0]    cnt_i,
    input  logic [WAIT_W-1:0]    lim_i,
    input  logic                 ack_i,
    output logic                 end_o
);
    logic count_met;

    assign count_met = (cnt_i >= lim_i);

    always_comb begin
        unique case (mode_i)
            ebus_pkg::WM_COUNT:  end_o = count_met;
            ebus_pkg::WM_ACK:    end_o = ack_i;
            ebus_pkg::WM_EITHER: end_o = count_met || ack_i;
            default:             end_o = count_met && ack_i;
        endcase
    end
endmodule

// File: rtl/ebus_wait_ctrl.sv
module ebus_wait_ctrl #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int NBANK  = 4,
    parameter int WAIT_W = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    req_i,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic                    done_o,
    output logic                    ready_o,
    input  logic [NBANK*WAIT_W-1:0] wait_cfg_i,
    input  logic [NBANK*2-1:0]      mode_cfg_i,
    input  logic [NBANK-1:0]        hold_cfg_i,
    input  logic [NBANK-1:0]        idle_cfg_i,
    input  logic                    ack_i,
    output logic [ADDR_W-1:0]       bus_addr_o,
    output logic [NBANK-1:0]        bus_sel_n_o,
    output logic                    bus_rd_n_o,
    output logic                    bus_wr_n_o,
    output logic [DATA_W-1:0]       bus_wdata_o,
    input  logic [DATA_W-1:0]       bus_rdata_i
);
    import ebus_pkg::*;

    localparam int BANK_W = $clog2(NBANK);

    typedef struct packed {
        bus_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              we;
        logic [BANK_W-1:0] bank;
        logic [WAIT_W-1:0] lim;
        wait_mode_e        mode;
        logic              hold;
        logic              idle;
        logic [WAIT_W-1:0] cnt;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [BANK_W-1:0] new_bank;
    logic [WAIT_W-1:0] new_lim;
    wait_mode_e        new_mode;
    logic              new_hold;
    logic              new_idle;
    logic              strobe_end;
    logic              sel_en;

    ebus_cfg_mux #(
        .ADDR_W (ADDR_W),
        .NBANK  (NBANK),
        .WAIT_W (WAIT_W)
    ) cfg_mux_i (
        .addr_i     (addr_i),
        .wait_cfg_i (wait_cfg_i),
        .mode_cfg_i (mode_cfg_i),
        .hold_cfg_i (hold_cfg_i),
        .idle_cfg_i (idle_cfg_i),
        .bank_o     (new_bank),
        .wait_o     (new_lim),
        .mode_o     (new_mode),
        .hold_o     (new_hold),
        .idle_o     (new_idle)
    );

    ebus_wait_eval #(
        .WAIT_W (WAIT_W)
    ) wait_eval_i (
        .mode_i (ctl_q.mode),
        .cnt_i  (ctl_q.cnt),
        .lim_i  (ctl_q.lim),
        .ack_i  (ack_i),
        .end_o  (strobe_end)
    );

    assign sel_en = (ctl_q.st == ST_STROBE) || (ctl_q.st == ST_HOLD);

    ebus_sel_dec #(
        .NBANK (NBANK)
    ) sel_dec_i (
        .bank_i  (ctl_q.bank),
        .en_i    (sel_en),
        .sel_n_o (bus_sel_n_o)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.st    = ST_STROBE;
                    ctl_d.addr  = addr_i;
                    ctl_d.wdata = wdata_i;
                    ctl_d.we    = we_i;
                    ctl_d.bank  = new_bank;
                    ctl_d.lim   = new_lim;
                    ctl_d.mode  = new_mode;
                    ctl_d.hold  = new_hold;
                    ctl_d.idle  = new_idle;
                    ctl_d.cnt   = '0;
                end
            end
            ST_STROBE: begin
                if (strobe_end) begin
                    ctl_d.done = 1'b1;
                    if (!ctl_q.we) begin
                        ctl_d.rdata = bus_rdata_i;
                    end
                    if (ctl_q.hold) begin
                        ctl_d.st = ST_HOLD;
                    end else if (ctl_q.idle) begin
                        ctl_d.st = ST_TURN;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end else if (ctl_q.cnt != '1) begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                ctl_d.st = ctl_q.idle ? ST_TURN : ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ready_o     = (ctl_q.st == ST_IDLE);
    assign done_o      = ctl_q.done;
    assign rdata_o     = ctl_q.rdata;
    assign bus_addr_o  = ctl_q.addr;
    assign bus_wdata_o = ctl_q.wdata;
    assign bus_rd_n_o  = !((ctl_q.st == ST_STROBE) && !ctl_q.we);
    assign bus_wr_n_o  = !((ctl_q.st == ST_STROBE) && ctl_q.we);
endmodule

// File: rtl/ebus_wait_ctrl_chk.sv
module ebus_wait_ctrl_chk #(
    parameter int ADDR_W = 24,
    parameter int NBANK  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              done_o,
    input logic              ready_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [NBANK-1:0]  bus_sel_n_o,
    input logic              bus_rd_n_o,
    input logic              bus_wr_n_o
);
    // R3
    rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!bus_rd_n_o && !bus_wr_n_o));

    // R2
    one_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~bus_sel_n_o));

    // R2
    strobe_has_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_rd_n_o || !bus_wr_n_o) |-> (bus_sel_n_o != '1));

    // R2
    addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((!bus_rd_n_o || !bus_wr_n_o) && $past(!bus_rd_n_o || !bus_wr_n_o))
        |-> $stable(bus_addr_o));

    // R10
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R10
    done_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (bus_rd_n_o && bus_wr_n_o && $past(!bus_rd_n_o || !bus_wr_n_o)));

    // R11
    ready_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> ((bus_sel_n_o == '1) && bus_rd_n_o && bus_wr_n_o));
endmodule

bind ebus_wait_ctrl ebus_wait_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .NBANK  (NBANK)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_o      (done_o),
    .ready_o     (ready_o),
    .bus_addr_o  (bus_addr_o),
    .bus_sel_n_o (bus_sel_n_o),
    .bus_rd_n_o  (bus_rd_n_o),
    .bus_wr_n_o  (bus_wr_n_o)
);

// File: tb/ebus_wait_ctrl_tb_top.sv
module ebus_wait_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [23:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        done;
    logic        ready;
    logic [11:0] wait_cfg = '0;
    logic [7:0]  mode_cfg = '0;
    logic [3:0]  hold_cfg = '0;
    logic [3:0]  idle_cfg = '0;
    logic        ack = 1'b0;
    logic [23:0] bus_addr;
    logic [3:0]  bus_sel_n;
    logic        bus_rd_n;
    logic        bus_wr_n;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ebus_wait_ctrl dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_i       (req),
        .we_i        (we),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .done_o      (done),
        .ready_o     (ready),
        .wait_cfg_i  (wait_cfg),
        .mode_cfg_i  (mode_cfg),
        .hold_cfg_i  (hold_cfg),
        .idle_cfg_i  (idle_cfg),
        .ack_i       (ack),
        .bus_addr_o  (bus_addr),
        .bus_sel_n_o (bus_sel_n),
        .bus_rd_n_o  (bus_rd_n),
        .bus_wr_n_o  (bus_wr_n),
        .bus_wdata_o (bus_wdata),
        .bus_rdata_i (bus_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_len(input int md, input int w, input int a);
        case (md)
            0:       return w + 1;
            1:       return a + 1;
            2:       return ((w < a) ? w : a) + 1;
            default: return ((w > a) ? w : a) + 1;
        endcase
    endfunction

    function automatic string len_tag(input int md);
        case (md)
            0:       return "R4";
            1:       return "R5";
            2:       return "R6";
            default: return "R7";
        endcase
    endfunction

    // One access; entered and left at a falling edge.
    task automatic do_access(input int bk, input bit wr, input int md, input int w,
                             input int a, input bit h, input bit id);
        logic [23:0] ad;
        logic [31:0] wd;
        logic [31:0] rd;
        logic [3:0]  sel_exp;
        int len;
        int exp;
        ad = {bk[1:0], 22'($urandom)};
        wd = $urandom;
        rd = $urandom;
        sel_exp = ~(4'b0001 << bk);
        wait_cfg[bk*3 +: 3] = w[2:0];
        mode_cfg[bk*2 +: 2] = md[1:0];
        hold_cfg[bk] = h;
        idle_cfg[bk] = id;
        while (!ready) @(negedge clk);
        req = 1'b1; we = wr; addr = ad; wdata = wd; bus_rdata = rd; ack = 1'b0;
        @(negedge clk);
        req = 1'b0;
        addr = 24'($urandom);
        wdata = $urandom;
        exp = exp_len(md, w, a);
        len = 0;
        while ((!bus_rd_n || !bus_wr_n) && len < 20) begin
            // R2
            chk(bus_sel_n == sel_exp, "R2", 32'(bus_sel_n), 32'(sel_exp));
            chk(bus_addr == ad, "R2", 32'(bus_addr), 32'(ad));
            // R3
            chk(bus_rd_n == wr && bus_wr_n == !wr, "R3", {30'd0, bus_rd_n, bus_wr_n}, {30'd0, wr, !wr});
            if (wr) chk(bus_wdata == wd, "R3", bus_wdata, wd);
            chk(!done, "R10", 32'(done), 0);
            // R4: in count-only mode the acknowledge is random noise
            ack = (md == 0) ? 1'($urandom) : (len >= a);
            len++;
            @(negedge clk);
        end
        ack = 1'b0;
        // R4 R5 R6 R7
        chk(len == exp, len_tag(md), 32'(len), 32'(exp));
        // R10
        chk(done, "R10", 32'(done), 1);
        if (!wr) chk(rdata == rd, "R10", rdata, rd);
        if (h) begin
            // R8
            chk(bus_sel_n == sel_exp && bus_addr == ad && bus_rd_n && bus_wr_n && !ready,
                "R8", {bus_sel_n, bus_addr, bus_rd_n, bus_wr_n, ready}[31:0],
                {sel_exp, ad, 1'b1, 1'b1, 1'b0}[31:0]);
            // R11: request while busy
            req = 1'b1; addr = 24'($urandom);
            @(negedge clk);
        end
        if (id) begin
            // R9
            chk(bus_sel_n == 4'hF && !ready && bus_rd_n && bus_wr_n, "R9",
                {27'd0, bus_sel_n, ready}, {27'd0, 4'hF, 1'b0});
            // R11: request while busy
            req = 1'b1; addr = 24'($urandom);
            @(negedge clk);
        end
        // R11
        chk(ready && bus_sel_n == 4'hF && bus_rd_n && bus_wr_n, "R11",
            {26'd0, ready, bus_sel_n, bus_rd_n}, {26'd0, 1'b1, 4'hF, 1'b1});
        req = 1'b0;
        @(negedge clk);
        // R10: single pulse, R11: the early request started nothing
        chk(!done, "R10", 32'(done), 0);
        chk(ready && bus_sel_n == 4'hF, "R11", {27'd0, ready, bus_sel_n}, {27'd0, 1'b1, 4'hF});
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(bus_sel_n == 4'hF && bus_rd_n && bus_wr_n && !done && ready, "R1",
            {25'd0, bus_sel_n, bus_rd_n, bus_wr_n, done, ready},
            {25'd0, 4'hF, 1'b1, 1'b1, 1'b0, 1'b1});
        // directed corners
        do_access(0, 0, 0, 0, 0, 0, 0);   // R4 minimum
        do_access(1, 1, 0, 7, 0, 0, 0);   // R4 maximum
        do_access(2, 0, 1, 3, 0, 0, 0);   // R5 ack in first cycle
        do_access(3, 1, 1, 0, 9, 1, 0);   // R5 long ack, R8
        do_access(0, 0, 2, 7, 9, 0, 1);   // R6 count first, R9
        do_access(1, 0, 2, 0, 5, 1, 1);   // R6 zero wait
        do_access(2, 1, 3, 0, 0, 0, 0);   // R7 both immediate
        do_access(3, 0, 3, 7, 2, 1, 1);   // R7 count dominates
        do_access(0, 1, 3, 1, 6, 0, 0);   // R7 ack dominates
        for (int i = 0; i < 200; i++) begin
            do_access(int'($urandom_range(3)), 1'($urandom), int'($urandom_range(3)),
                      int'($urandom_range(7)), int'($urandom_range(9)),
                      1'($urandom), 1'($urandom));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule